// File: doc/BRIEF.md
# Bonded Lane Start Alignment

This block makes every transmit lane in a bonded group begin on one shared clock cycle. All lanes run on a common parallel clock. One lane is the source lane. A start request from the source lane is passed outward, one neighbour at a time, through a chain of registered hops. Each hop costs a fixed number of cycles. Because of this, lanes far from the source receive the token later than lanes close to it.

To cancel that skew, each lane holds its token for a compensating number of cycles. The compensation is the difference between the farthest hop distance in the group and the lane's own distance, multiplied by the hop latency. Every lane then emits a one-cycle start pulse on the same edge.

Each lane also keeps a free-running state counter that clears when the lane starts. Equal counter values across the lanes show that the group is aligned. Integration logic sets the lane count, the source position and the hop latency as parameters, then drives a single request input.

Top module: `bond_start_align`

## Requirements
- R1: A request sampled high at a clock edge while the group is idle is accepted. Every lane's start pulse is set at the edge that comes HOP_LAT*Dmax edges later. Dmax is the largest value of |i - MASTER_IDX| over all lanes and HOP_LAT defaults to 2. A group of 6 lanes with the default source has a latency of 6 edges. A group of 4 lanes with the source at index 0 also has a latency of 6. A group of 5 lanes with the default source has a latency of 4.
- R2: Whenever any lane's start bit (lane_start[i] for lane i) is high, the start bits of all lanes in the group are high.
- R3: Each accepted request makes each lane pulse exactly once, for exactly one cycle. No lane pulses when no request has been accepted.
- R4: The default source position is (NUM_LANES-1)/2, the centre lane, taking the lower of the two centre lanes when the count is even. The token travels through every lane between the source and a given lane, in index order.
- R5: Each lane's state counter is STATE_W bits wide and sits in lane_state[i*STATE_W +: STATE_W]. It reads 0 during reset and rises by 1 each cycle. It reads 0 in the cycle after that lane's start pulse. All lanes' counters are equal on every cycle.
- R6: A synchronous reset clears the launch register, every hop register and every compensation register. A request that is in flight when reset is applied produces no pulse afterwards.
- R7: A request that arrives at any edge from the accepting edge up to and including the pulse edge is ignored. A request at the edge right after the pulse edge is accepted.
- R8: A group of one lane has Dmax = 0. It pulses at the same edge that accepts the request, and it can accept a request at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start request at the source lane |
| lane_start | output | NUM_LANES | One-cycle start pulse per lane |
| lane_state | output | NUM_LANES*STATE_W | Per-lane state counters, lane i in bits i*STATE_W upward |

## Verification
The bench counts edges from the edge that accepts a request. It expects the start pulses in the cycle after edge HOP_LAT*Dmax. It expects the state counters to read 0 one cycle later and to read 3 three cycles after that. Dmax is found separately for each instance from its lane count and source position. Four instances with different group shapes share one request, and each is compared on every cycle of a window. Outputs are sampled on the falling edge, and request and reset are timed to the cycle. This places the re-requests inside the busy window, on the pulse edge and on the edge just after it, and it places the reset in the middle of the chain.

// File: rtl/bond_align_pkg.sv
`timescale 1ns/1ps
package bond_align_pkg;

  // Hop count between a lane and the source lane.
  function automatic int hop_dist(input int lane, input int src);
    return (lane > src) ? (lane - src) : (src - lane);
  endfunction

  // Largest hop count in the group.
  function automatic int max_dist(input int lanes, input int src);
    int far_hi;
    far_hi = lanes - 1 - src;
    return (far_hi > src) ? far_hi : src;
  endfunction

  // Hold time a lane adds so that it lines up with the farthest lane.
  function automatic int comp_cycles(input int lane, input int lanes, input int src, input int hop);
    return hop * (max_dist(lanes, src) - hop_dist(lane, src));
  endfunction

  // Edges from request acceptance to the aligned pulse.
  function automatic int total_latency(input int lanes, input int src, input int hop);
    return hop * max_dist(lanes, src);
  endfunction

endpackage

// File: rtl/bond_delay_line.sv
`timescale 1ns/1ps
module bond_delay_line #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  if (DEPTH == 0) begin : pass_g
    assign q = d;
  end else begin : reg_g
    logic [DEPTH-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) begin
        sr <= '0;
      end else begin
        sr[0] <= d;
        for (int j = 1; j < DEPTH; j++) sr[j] <= sr[j-1];
      end
    end
    assign q = sr[DEPTH-1];
  end
endmodule

// File: rtl/bond_launch_ctrl.sv
`timescale 1ns/1ps
module bond_launch_ctrl #(
  parameter int LAT = 6,
  localparam int CW = $clog2(LAT + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  output logic          launch_o,
  output logic          busy_o,
  output logic [CW-1:0] in_flight_o
);
  logic accept;
  logic [CW-1:0] cnt_q;

  assign busy_o      = (cnt_q != '0);
  assign accept      = start_req && !busy_o;
  assign in_flight_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      launch_o <= 1'b0;
      cnt_q    <= '0;
    end else begin
      launch_o <= accept;
      if (accept)          cnt_q <= CW'(LAT);
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7
  ignored_req_chk: assert property (@(posedge clk) disable iff (rst)
    (start_req && busy_o) |=> !launch_o);

  // R7
  drain_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (in_flight_o == $past(in_flight_o) - 1'b1));
endmodule

// File: rtl/bond_lane.sv
`timescale 1ns/1ps
module bond_lane #(
  parameter int COMP    = 0,
  parameter int STATE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tok_in,
  output logic               start_o,
  output logic [STATE_W-1:0] state_o
);
  bond_delay_line #(.DEPTH(COMP)) comp_u (
    .clk (clk),
    .rst (rst),
    .d   (tok_in),
    .q   (start_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          state_o <= '0;
    else if (start_o) state_o <= '0;
    else              state_o <= state_o + 1'b1;
  end

  // R5
  state_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> (state_o == '0));
endmodule

// File: rtl/bond_start_align.sv
`timescale 1ns/1ps
module bond_start_align
  import bond_align_pkg::*;
#(
  parameter int NUM_LANES  = 6,
  parameter int MASTER_IDX = (NUM_LANES - 1) / 2,
  parameter int HOP_LAT    = 2,
  parameter int STATE_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_req,
  output logic [NUM_LANES-1:0]         lane_start,
  output logic [NUM_LANES*STATE_W-1:0] lane_state
);
  localparam int DMAX = max_dist(NUM_LANES, MASTER_IDX);
  localparam int LAT  = total_latency(NUM_LANES, MASTER_IDX, HOP_LAT);
  localparam int CW   = $clog2(LAT + 2);

  logic                 launch;
  logic                 busy;
  logic [CW-1:0]        in_flight;
  logic [NUM_LANES-1:0] tok_in;

  bond_launch_ctrl #(.LAT(LAT)) launch_u (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .launch_o    (launch),
    .busy_o      (busy),
    .in_flight_o (in_flight)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : lane_g
    localparam int COMP = comp_cycles(i, NUM_LANES, MASTER_IDX, HOP_LAT);

    if (i == MASTER_IDX) begin : src_g
      assign tok_in[i] = launch;
    end else if (i < MASTER_IDX) begin : lo_g
      bond_delay_line #(.DEPTH(HOP_LAT)) hop_u (
        .clk (clk), .rst (rst), .d (tok_in[i+1]), .q (tok_in[i]));
    end else begin : hi_g
      bond_delay_line #(.DEPTH(HOP_LAT)) hop_u (
        .clk (clk), .rst (rst), .d (tok_in[i-1]), .q (tok_in[i]));
    end

    bond_lane #(.COMP(COMP), .STATE_W(STATE_W)) lane_u (
      .clk     (clk),
      .rst     (rst),
      .tok_in  (tok_in[i]),
      .start_o (lane_start[i]),
      .state_o (lane_state[i*STATE_W +: STATE_W])
    );

    if (i != MASTER_IDX) begin : align_g
      // R5
      state_align_chk: assert property (@(posedge clk) disable iff (rst)
        lane_state[i*STATE_W +: STATE_W] == lane_state[MASTER_IDX*STATE_W +: STATE_W]);
    end
  end

  // R2
  pulse_coincide_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_start == '0) || (lane_start == '1));

  if (LAT > 0) begin : lat_g
    // R1
    pulse_timing_chk: assert property (@(posedge clk) disable iff (rst)
      lane_start[MASTER_IDX] |-> (in_flight == '0) && ($past(in_flight) == CW'(1)));

    // R3
    single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      lane_start[MASTER_IDX] |=> !lane_start[MASTER_IDX]);
  end

  // R4
  initial begin
    src_range_chk: assert (MASTER_IDX >= 0 && MASTER_IDX < NUM_LANES && HOP_LAT >= 1 && DMAX >= 0);
  end
endmodule

// File: tb/tb_bond_start_align.sv
`timescale 1ns/1ps
module tb_bond_start_align;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [5:0]    s6; logic [6*SW-1:0] st6;
  logic [3:0]    s4; logic [4*SW-1:0] st4;
  logic [4:0]    s5; logic [5*SW-1:0] st5;
  logic [0:0]    s1; logic [1*SW-1:0] st1;

  bond_start_align #(.NUM_LANES(6)) dut (
    .clk(clk), .rst(rst), .start_req(req), .lane_start(s6), .lane_state(st6));
  bond_start_align #(.NUM_LANES(4), .MASTER_IDX(0)) dut_edge (
    .clk(clk), .rst(rst), .start_req(req), .lane_start(s4), .lane_state(st4));
  bond_start_align #(.NUM_LANES(5)) dut_odd (
    .clk(clk), .rst(rst), .start_req(req), .lane_start(s5), .lane_state(st5));
  bond_start_align #(.NUM_LANES(1)) dut_one (
    .clk(clk), .rst(rst), .start_req(req), .lane_start(s1), .lane_state(st1));

  function automatic int lanes_of(input int w);
    case (w) 0: return 6; 1: return 4; 2: return 5; default: return 1;
  endcase
  endfunction

  function automatic int src_of(input int w);
    if (w == 1) return 0;
    return (lanes_of(w) - 1) / 2;   // R4 centre, lower one when even
  endfunction

  function automatic int lat_of(input int w);
    int far = 0;
    for (int i = 0; i < lanes_of(w); i++) begin
      int d = (i > src_of(w)) ? i - src_of(w) : src_of(w) - i;
      if (d > far) far = d;
    end
    return 2 * far;
  endfunction

  function automatic logic [63:0] pulses(input int w);
    case (w)
      0: return 64'(s6); 1: return 64'(s4); 2: return 64'(s5); default: return 64'(s1);
    endcase
  endfunction

  function automatic logic [63:0] states(input int w);
    case (w)
      0: return 64'(st6); 1: return 64'(st4); 2: return 64'(st5); default: return 64'(st1);
    endcase
  endfunction

  function automatic logic [63:0] all_lanes(input int w);
    return (64'd1 << lanes_of(w)) - 64'd1;
  endfunction

  function automatic logic [63:0] rep_state(input int w, input int v);
    logic [63:0] r = '0;
    for (int i = 0; i < lanes_of(w); i++) r[i*SW +: SW] = SW'(v);
    return r;
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s at %0t: actual %h expected %h", rq, $time, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R5 R6: outputs held at zero during reset
  task automatic t_reset();
    idle(3);
    for (int w = 0; w < 4; w++) begin
      chk("R6 reset pulses", pulses(w), 64'd0);
      chk("R5 reset state", states(w), 64'd0);
    end
    rst = 1'b0;
    idle(5);
    for (int w = 0; w < 4; w++) chk("R3 no pulse when idle", pulses(w), 64'd0);
  endtask

  // R1 R2 R3 R4 R5 R8: latency, coincidence, single pulse, counters
  task automatic t_sweep();
    pulse_req();
    for (int k = 0; k <= 10; k++) begin
      for (int w = 0; w < 4; w++) begin
        logic [63:0] exp = (k == lat_of(w)) ? all_lanes(w) : 64'd0;
        if (w == 3) chk("R8 single lane pulse edge", pulses(w), exp);
        else        chk("R1 R2 R3 pulse timing", pulses(w), exp);
        if (k == lat_of(w) + 1) chk("R5 state cleared", states(w), rep_state(w, 0));
        if (k == lat_of(w) + 4) chk("R5 state counting", states(w), rep_state(w, 3));
      end
      @(negedge clk);
    end
  endtask

  // R7: requests in flight ignored, next edge after pulse accepted
  task automatic t_ignore();
    idle(4);
    pulse_req();
    for (int k = 0; k <= 16; k++) begin
      logic [63:0] exp = (k == 6 || k == 13) ? all_lanes(0) : 64'd0;
      chk("R7 busy requests ignored", pulses(0), exp);
      req = (k == 1 || k == 5 || k == 6);
      @(negedge clk);
    end
    req = 1'b0;
    idle(10);
  endtask

  // R6: reset in the middle of the chain drops the start
  task automatic t_reset_mid();
    pulse_req();
    for (int k = 0; k <= 12; k++) begin
      if (k >= 3) for (int w = 0; w < 4; w++) chk("R6 no stale pulse", pulses(w), 64'd0);
      rst = (k == 2);
      @(negedge clk);
    end
    for (int w = 0; w < 4; w++)
      chk("R5 counters equal after reset", states(w), rep_state(w, states(w)[SW-1:0]));
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_ignore();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule